// File: doc/BRIEF.md
# Microcontroller GPIO Port with Peripheral Pin Overrides

This block is one parallel I/O port of a small microcontroller, eight pins wide by default. Software configures each pin through a direction register and an output-data register. A port-wide control register holds a global pull-up disable bit. The block turns these settings into the four pad controls of each pin: output enable, output level, pull-up enable and digital input enable. The raw pad level is resampled through a two-flop synchronizer into a pin-read value that software can read.

On-chip peripherals can take over any part of a pin. Each of the four pad controls has its own pair of buses, one override-enable bus and one override-value bus, with one bit per pin. When a pin's enable bit is set, its value bit replaces the register-derived setting for that pin. A peripheral also gets the pad level before synchronization on a separate output, gated by the pin's input enable. The peripheral resynchronizes it unless it uses that input as a clock.

Top module: `gpio_ovr_port`

## Requirements
- R1: While reset is asserted and after it is released, the direction, output-data and control registers read 0. With no overrides active, every pin then has output enable 0 and pull-up enable 0.
- R2: Each write strobe loads `wdata` into its register on the next rising clock edge: `wr_dir` loads direction, `wr_data` loads output data and `wr_ctrl` loads control. `rdata` shows the register chosen by `rd_sel`: 0 selects direction, 1 selects output data, 2 selects pin read and 3 selects control.
- R3: When a pin's pull-up override enable is 0, its pull-up is on exactly when its direction bit is 0, its output-data bit is 1 and control bit 2 (global pull-up disable) is 0.
- R4: When a pin's pull-up override enable is 1, its pull-up equals its pull-up override value. Direction, data and the global disable have no effect.
- R5: A pin's output enable equals its direction override value when the direction override enable is 1. Otherwise it equals the pin's direction bit.
- R6: When a pin's output enable is 1, its output level is the port-value override value if the port-value override enable is 1, and the output-data bit otherwise. When the output enable is 0, the output level is 0.
- R7: A pin's input enable equals its input-enable override value when that override enable is 1. Otherwise it is 1 when `sleep_mode` is 0 and 0 when `sleep_mode` is 1.
- R8: The pin-read value of a pin equals `pad_in AND input enable`, as sampled at the rising edge two edges before the current one. A pad change is therefore readable after two clocks, and a pin whose input is disabled reads 0.
- R9: `periph_din` equals `pad_in AND input enable` with no clock delay.
- R10: All eight control bits can be written and read back. Only bit 2 affects the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| wr_dir | input | 1 | Write strobe for the direction register |
| wr_data | input | 1 | Write strobe for the output-data register |
| wr_ctrl | input | 1 | Write strobe for the control register |
| wdata | input | 8 | Write data |
| rd_sel | input | 2 | Read select: 0 direction, 1 data, 2 pin read, 3 control |
| rdata | output | 8 | Read data |
| sleep_mode | input | 1 | 1 when the MCU is in a sleep mode that turns digital inputs off |
| pu_ovr_en | input | 8 | Pull-up override enable, one bit per pin |
| pu_ovr_val | input | 8 | Pull-up override value |
| dd_ovr_en | input | 8 | Output-enable override enable |
| dd_ovr_val | input | 8 | Output-enable override value |
| pv_ovr_en | input | 8 | Output-level override enable |
| pv_ovr_val | input | 8 | Output-level override value |
| ie_ovr_en | input | 8 | Input-enable override enable |
| ie_ovr_val | input | 8 | Input-enable override value |
| pad_in | input | 8 | Raw pad levels |
| pad_oe | output | 8 | Pad output enable |
| pad_out | output | 8 | Pad output level |
| pad_pu | output | 8 | Pad pull-up enable |
| pad_ie | output | 8 | Pad digital input enable |
| periph_din | output | 8 | Unsynchronized input to peripherals |

## Verification
A directed phase uses only the registers. Direction, data and the global disable step through combinations that turn the pull-up on, turn it off through the global disable, and turn it off by driving the pin. This separates R3 from the output path. Random phases follow. In the first, only one override pair is active at a time, so a wrong enable-to-value pairing shows up as an error on one pad control. In the second, all pairs and `sleep_mode` are randomized together, which tests that the overrides layer correctly. Pad levels change every cycle while input enables toggle, so the two-clock read latency and the gating to zero can be told apart from a one-clock or ungated path.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  typedef enum logic [1:0] {
    RSEL_DIR  = 2'd0,
    RSEL_DATA = 2'd1,
    RSEL_PIN  = 2'd2,
    RSEL_CTRL = 2'd3
  } rsel_e;

  typedef struct packed {
    logic oe;
    logic out;
    logic pu;
    logic ie;
  } pad_ctl_t;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_ovr_pkg::*;
#(
  parameter int W       = 8,
  parameter int PUD_BIT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_dir,
  input  logic         wr_data,
  input  logic         wr_ctrl,
  input  logic [W-1:0] wdata,
  input  logic [1:0]   rd_sel,
  input  logic [W-1:0] pin_val,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] data_q,
  output logic         pud,
  output logic [W-1:0] rdata
);
  logic [W-1:0] ctrl_q;
  logic [W-1:0] dir_d, data_d, ctrl_d;
  logic         dir_en, data_en, ctrl_en;

  always_comb begin
    dir_en  = wr_dir;
    data_en = wr_data;
    ctrl_en = wr_ctrl;
    dir_d   = wdata;
    data_d  = wdata;
    ctrl_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      data_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (dir_en)  dir_q  <= dir_d;
      if (data_en) data_q <= data_d;
      if (ctrl_en) ctrl_q <= ctrl_d;
    end
  end

  assign pud = ctrl_q[PUD_BIT];

  always_comb begin
    unique case (rsel_e'(rd_sel))
      RSEL_DIR:  rdata = dir_q;
      RSEL_DATA: rdata = data_q;
      RSEL_PIN:  rdata = pin_val;
      default:   rdata = ctrl_q;
    endcase
  end

  // R2: a strobed write is visible on the following cycle
  p_dir_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> dir_q == $past(wdata));
  p_data_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> data_q == $past(wdata));
  // R10: every control bit holds what was written
  p_ctrl_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (rsel_e'(rd_sel) != RSEL_CTRL) || (rdata == $past(wdata)));
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_ovr_pkg::*;
(
  input  logic     dir_bit,
  input  logic     data_bit,
  input  logic     pud,
  input  logic     sleep_mode,
  input  logic     pu_en,
  input  logic     pu_val,
  input  logic     dd_en,
  input  logic     dd_val,
  input  logic     pv_en,
  input  logic     pv_val,
  input  logic     ie_en,
  input  logic     ie_val,
  input  logic     pad_lvl,
  output pad_ctl_t ctl,
  output logic     din
);
  logic pu_dflt, drv, lvl, ie;

  always_comb begin
    pu_dflt = ~dir_bit & data_bit & ~pud;
    drv     = dd_en ? dd_val : dir_bit;
    lvl     = pv_en ? pv_val : data_bit;
    ie      = ie_en ? ie_val : ~sleep_mode;
    ctl.oe  = drv;
    ctl.out = drv & lvl;
    ctl.pu  = pu_en ? pu_val : pu_dflt;
    ctl.ie  = ie;
    din     = pad_lvl & ie;
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  input  logic [W-1:0] gate,
  output logic [W-1:0] q_out
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d_in & gate;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
    end
  end

  assign q_out = stg_q[STAGES-1];

  // R8: a pin captured while its input was disabled enters as 0
  p_gate_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stg_q[0] & ~$past(gate)) == '0);
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int W           = 8,
  parameter int PUD_BIT     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_dir,
  input  logic         wr_data,
  input  logic         wr_ctrl,
  input  logic [W-1:0] wdata,
  input  logic [1:0]   rd_sel,
  output logic [W-1:0] rdata,
  input  logic         sleep_mode,
  input  logic [W-1:0] pu_ovr_en,
  input  logic [W-1:0] pu_ovr_val,
  input  logic [W-1:0] dd_ovr_en,
  input  logic [W-1:0] dd_ovr_val,
  input  logic [W-1:0] pv_ovr_en,
  input  logic [W-1:0] pv_ovr_val,
  input  logic [W-1:0] ie_ovr_en,
  input  logic [W-1:0] ie_ovr_val,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pu,
  output logic [W-1:0] pad_ie,
  output logic [W-1:0] periph_din
);
  logic [W-1:0] dir_q, data_q, pin_val;
  logic         pud;
  pad_ctl_t     ctl [W];

  gpio_regs #(.W(W), .PUD_BIT(PUD_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_dir(wr_dir), .wr_data(wr_data), .wr_ctrl(wr_ctrl),
    .wdata(wdata), .rd_sel(rd_sel), .pin_val(pin_val),
    .dir_q(dir_q), .data_q(data_q), .pud(pud), .rdata(rdata)
  );

  for (genvar i = 0; i < W; i++) begin : g_pin
    gpio_pin_ctrl u_pin (
      .dir_bit(dir_q[i]), .data_bit(data_q[i]), .pud(pud),
      .sleep_mode(sleep_mode),
      .pu_en(pu_ovr_en[i]), .pu_val(pu_ovr_val[i]),
      .dd_en(dd_ovr_en[i]), .dd_val(dd_ovr_val[i]),
      .pv_en(pv_ovr_en[i]), .pv_val(pv_ovr_val[i]),
      .ie_en(ie_ovr_en[i]), .ie_val(ie_ovr_val[i]),
      .pad_lvl(pad_in[i]),
      .ctl(ctl[i]), .din(periph_din[i])
    );
    assign pad_oe[i]  = ctl[i].oe;
    assign pad_out[i] = ctl[i].out;
    assign pad_pu[i]  = ctl[i].pu;
    assign pad_ie[i]  = ctl[i].ie;
  end

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_in(pad_in), .gate(pad_ie), .q_out(pin_val)
  );

  // R6: an undriven pad never shows a 1 level
  p_out_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);
  // R3: the global disable blocks every pull-up not under override
  p_pud_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pud |-> (pad_pu & ~pu_ovr_en) == '0);
  // R9: a disabled input passes nothing to peripherals
  p_din_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_din & ~pad_ie) == '0);

  if (SYNC_STAGES == 2) begin : g_lat_chk
    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end
    // R8: pin read lags the gated pad by two edges
    p_pin_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd2) |-> pin_val == $past(pad_in & pad_ie, 2));
  end
endmodule

// File: tb/sim_gpio_ovr_port.sv
module sim_gpio_ovr_port;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_dir = 0, wr_data = 0, wr_ctrl = 0;
  logic [W-1:0] wdata = '0;
  logic [1:0] rd_sel = '0;
  logic [W-1:0] rdata;
  logic sleep_mode = 0;
  logic [W-1:0] pu_ovr_en = '0, pu_ovr_val = '0, dd_ovr_en = '0, dd_ovr_val = '0;
  logic [W-1:0] pv_ovr_en = '0, pv_ovr_val = '0, ie_ovr_en = '0, ie_ovr_val = '0;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_oe, pad_out, pad_pu, pad_ie, periph_din;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_ovr_port u0 (
    .clk(clk), .rst_n(rst_n), .wr_dir(wr_dir), .wr_data(wr_data), .wr_ctrl(wr_ctrl),
    .wdata(wdata), .rd_sel(rd_sel), .rdata(rdata), .sleep_mode(sleep_mode),
    .pu_ovr_en(pu_ovr_en), .pu_ovr_val(pu_ovr_val),
    .dd_ovr_en(dd_ovr_en), .dd_ovr_val(dd_ovr_val),
    .pv_ovr_en(pv_ovr_en), .pv_ovr_val(pv_ovr_val),
    .ie_ovr_en(ie_ovr_en), .ie_ovr_val(ie_ovr_val),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
    .pad_ie(pad_ie), .periph_din(periph_din)
  );

  // Reference model state
  logic [W-1:0] m_dir = '0, m_data = '0, m_ctrl = '0;
  logic [W-1:0] m_pipe[$] = '{8'h00, 8'h00};

  function automatic logic [W-1:0] exp_ie();
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = ie_ovr_en[i] ? ie_ovr_val[i] : !sleep_mode;
    return r;
  endfunction

  function automatic logic [W-1:0] exp_oe();
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = dd_ovr_en[i] ? dd_ovr_val[i] : m_dir[i];
    return r;
  endfunction

  function automatic logic [W-1:0] exp_out();
    logic [W-1:0] r;
    logic [W-1:0] oe = exp_oe();
    for (int i = 0; i < W; i++)
      r[i] = !oe[i] ? 1'b0 : (pv_ovr_en[i] ? pv_ovr_val[i] : m_data[i]);
    return r;
  endfunction

  function automatic logic [W-1:0] exp_pu();
    logic [W-1:0] r;
    for (int i = 0; i < W; i++)
      r[i] = pu_ovr_en[i] ? pu_ovr_val[i] : (!m_dir[i] && m_data[i] && !m_ctrl[2]);
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = '0; m_data = '0; m_ctrl = '0;
      m_pipe = '{8'h00, 8'h00};
    end else begin
      if (wr_dir)  m_dir  = wdata;
      if (wr_data) m_data = wdata;
      if (wr_ctrl) m_ctrl = wdata;
      m_pipe.push_back(pad_in & exp_ie());
      void'(m_pipe.pop_front());
    end
  end

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%02h expected=%02h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R5", "pad_oe", pad_oe, exp_oe());
    chk("R6", "pad_out", pad_out, exp_out());
    chk(pu_ovr_en != 0 ? "R4" : "R3", "pad_pu", pad_pu, exp_pu());
    chk("R7", "pad_ie", pad_ie, exp_ie());
    chk("R9", "periph_din", periph_din, pad_in & exp_ie());
    case (rd_sel)
      2'd0: chk("R2", "rdata dir", rdata, m_dir);
      2'd1: chk("R2", "rdata data", rdata, m_data);
      2'd2: chk("R8", "rdata pin", rdata, m_pipe[0]);
      default: chk("R10", "rdata ctrl", rdata, m_ctrl);
    endcase
  endtask

  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/4);
    check_all();
  endtask

  task automatic wr(int which, logic [W-1:0] v);
    wr_dir = (which == 0); wr_data = (which == 1); wr_ctrl = (which == 2);
    wdata = v;
    step();
    wr_dir = 0; wr_data = 0; wr_ctrl = 0;
  endtask

  initial begin
    // R1: reset state, every read select
    for (int c = 0; c < 4; c++) begin
      rd_sel = 2'(c);
      pad_in = 8'hA5;
      @(posedge clk);
      #(CLK_PERIOD/4);
      chk("R1", "rdata in reset", rdata, 8'h00);
      chk("R1", "pad_oe in reset", pad_oe, 8'h00);
      chk("R1", "pad_pu in reset", pad_pu, 8'h00);
    end
    rst_n = 1'b1;
    pad_in = 8'h00;
    step();
    chk("R1", "pad_oe after reset", pad_oe, 8'h00);
    chk("R1", "pad_pu after reset", pad_pu, 8'h00);

    // Directed: register-only pull-up and drive paths (R3, R5, R6, R10)
    rd_sel = 2'd1;
    wr(1, 8'hFF);
    chk("R3", "pull-up all on", pad_pu, 8'hFF);
    rd_sel = 2'd3;
    wr(2, 8'h04);
    chk("R3", "global disable", pad_pu, 8'h00);
    wr(2, 8'hFB);
    chk("R10", "other ctrl bits no effect", pad_pu, 8'hFF);
    chk("R10", "ctrl readback", rdata, 8'hFB);
    rd_sel = 2'd0;
    wr(0, 8'h0F);
    chk("R3", "driven pins lose pull-up", pad_pu, 8'hF0);
    chk("R6", "driven level", pad_out, 8'h0F);
    wr(1, 8'h5A);
    chk("R6", "data to pad", pad_out, 8'h0A);

    // Directed: latency of pin read (R8)
    rd_sel = 2'd2;
    pad_in = 8'h3C;
    step();
    step();
    chk("R8", "pad after two edges", rdata, 8'h3C);
    sleep_mode = 1;
    pad_in = 8'hFF;
    step(); step(); step();
    chk("R8", "sleep gates pin read", rdata, 8'h00);
    sleep_mode = 0;

    // Random: one override pair at a time
    for (int n = 0; n < 2000; n++) begin
      logic [W-1:0] e = W'($urandom);
      logic [W-1:0] v = W'($urandom);
      int k = n % 4;
      pu_ovr_en = (k == 0) ? e : '0; pu_ovr_val = v;
      dd_ovr_en = (k == 1) ? e : '0; dd_ovr_val = v;
      pv_ovr_en = (k == 2) ? e : '0; pv_ovr_val = v;
      ie_ovr_en = (k == 3) ? e : '0; ie_ovr_val = v;
      pad_in = W'($urandom);
      rd_sel = 2'($urandom);
      sleep_mode = ($urandom % 4) == 0;
      case ($urandom % 6)
        0: begin wr_dir = 1; wdata = W'($urandom); end
        1: begin wr_data = 1; wdata = W'($urandom); end
        2: begin wr_ctrl = 1; wdata = W'($urandom); end
        default: ;
      endcase
      step();
      wr_dir = 0; wr_data = 0; wr_ctrl = 0;
    end

    // Random: everything layered
    for (int n = 0; n < 3000; n++) begin
      pu_ovr_en = W'($urandom); pu_ovr_val = W'($urandom);
      dd_ovr_en = W'($urandom); dd_ovr_val = W'($urandom);
      pv_ovr_en = W'($urandom); pv_ovr_val = W'($urandom);
      ie_ovr_en = W'($urandom); ie_ovr_val = W'($urandom);
      pad_in = W'($urandom);
      rd_sel = 2'($urandom);
      sleep_mode = $urandom % 2;
      wr_dir = ($urandom % 5) == 0;
      wr_data = ($urandom % 5) == 0;
      wr_ctrl = ($urandom % 5) == 0;
      wdata = W'($urandom);
      step();
      wr_dir = 0; wr_data = 0; wr_ctrl = 0;
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule